// File: doc/BRIEF.md
# ADC Conversion Auto-Sequencer

This block is the digital controller that sits in front of an external analog-to-digital converter. It walks a pointer through a programmable table of channel selections and starts one conversion per table state over a start/done handshake. Each 12-bit answer is stored, left-justified, in one of sixteen result registers. The block runs either as one sixteen-state sequencer (cascaded mode) or as two independent eight-state sequencers that take turns on the shared converter (dual mode).

A trigger starts a session of a programmed number of conversions. Between sessions the pointer holds where it stopped, so one table can be consumed across several triggers. A restart option repeats sessions without new triggers. A wrap option chooses whether the pointer returns to the start of its range after every session or only after the final state. A reset command returns the pointer to its initial state at once. Each sequencer can raise an end-of-sequence interrupt on every session or on every second session. A paired sampling mode converts the A and B inputs of one index together and stores two results per state.

Top module: `adc_autoseq`

## Requirements
- R1: Table state s uses the 4-bit entry `chanTable[4s+3:4s]`, so entry 0 sits in bits 3:0 and each 16-bit word holds four entries. While `convStart` is high in sequential mode, `convChan` equals the entry of the current state.
- R2: In cascaded mode (`cascadeMode`=1) sequencer A covers states 0 to 15, and `trigB` and `rstSeqB` have no effect, so `busyB` stays 0. In dual mode sequencer A covers states 0 to 7 and sequencer B covers states 8 to 15, and reset or power-up puts A at state 0 and B at state 8.
- R3: A session performs the count field plus one conversions. The count field is `maxConvA` for A in cascaded mode, `maxConvA[2:0]` for A in dual mode, and `maxConvB` for B. A session also ends early when it converts the final state of its range.
- R4: With `contRun`=0, when a session ends the pointer moves to the next state and the sequencer waits there for a trigger. The next trigger continues from that state. After the final state of the range the pointer returns to the initial state.
- R5: With `contRun`=1 and `wrapOverride`=0, a finished session restarts at once without a trigger (busy stays high), and the pointer returns to the initial state after every session.
- R6: With `contRun`=1 and `wrapOverride`=1, sessions restart at once, and the pointer keeps advancing across sessions. It returns to the initial state only after the final state of the range.
- R7: A reset command (`rstSeqA`, or `rstSeqB` in dual mode) sampled on a clock edge sets that sequencer's pointer to its initial state and clears its every-other-interrupt phase. If the sequencer was running, the session is abandoned (busy low after that edge, no result write, no interrupt). A trigger to the same sequencer in the same cycle is dropped.
- R8: At the end of a session the sequencer's `irq` output pulses for one cycle if its enable is 1. With mode 0 this happens on every session end. With mode 1 it happens on the second, fourth and later session ends, counted from reset.
- R9: Each result register holds the 12-bit code in bits 15:4 with bits 3:0 zero. Code 0xFFF reads 0xFFF0 and code 0x001 reads 0x0010, and every register is 0 after reset.
- R10: With `simulMode`=1, a state's start pulse carries `convPair`=1 and `convChan`={0, entry[2:0]}. The done returns `convData` (input A) and `convDataB` (input B). For state s in a range with base b and size n, these go to registers b+((2(s-b)) mod n) and that index plus one.
- R11: `busyA`/`busyB` rises on the edge that accepts a trigger and falls on the edge that samples the final done of the session. A trigger is accepted only while no session of either sequencer is active. `trigA` wins over a simultaneous `trigB`.
- R12: `convStart` is a one-cycle pulse in the cycle after trigger acceptance, or in the cycle after the previous done. A done is accepted only after a start, and the result register, pointer and interrupt update on the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cascadeMode | input | 1 | 1 = one 16-state sequencer, 0 = two 8-state sequencers |
| simulMode | input | 1 | 1 = paired A/B sampling per state |
| contRun | input | 1 | Restart sessions automatically |
| wrapOverride | input | 1 | Pointer wraps only after the final state when restarting |
| maxConvA | input | 4 | Conversions per session minus one, sequencer A |
| maxConvB | input | 3 | Conversions per session minus one, sequencer B |
| chanTable | input | 64 | Channel-select table, 16 entries of 4 bits |
| trigA | input | 1 | Start trigger, sequencer A |
| trigB | input | 1 | Start trigger, sequencer B (dual mode) |
| rstSeqA | input | 1 | Pointer reset command, sequencer A |
| rstSeqB | input | 1 | Pointer reset command, sequencer B (dual mode) |
| intEnA | input | 1 | Interrupt enable, A |
| intModeA | input | 1 | 0 = every session end, 1 = every second, A |
| intEnB | input | 1 | Interrupt enable, B |
| intModeB | input | 1 | 0 = every session end, 1 = every second, B |
| convStart | output | 1 | One-cycle conversion start |
| convChan | output | 4 | Channel number for the start |
| convPair | output | 1 | Paired sampling request with the start |
| convDone | input | 1 | Conversion complete |
| convData | input | 12 | Converted code (input A) |
| convDataB | input | 12 | Converted code (input B, paired mode) |
| busyA | output | 1 | Sequencer A session active |
| busyB | output | 1 | Sequencer B session active |
| irqA | output | 1 | End-of-sequence interrupt pulse, A |
| irqB | output | 1 | End-of-sequence interrupt pulse, B |
| resultsFlat | output | 256 | Sixteen 16-bit result registers, register k in bits 16k+15:16k |

## Verification
The assertions check on every cycle that a start lasts one cycle and only inside a session, and that the two sequencers are never busy together. They also check that a reset command leaves its sequencer idle, that interrupts follow a done, that results keep their low nibble clear, and that a paired start names an A channel. Only the bench scenarios can show what depends on history across sessions. That covers the pointer held between triggers, the wrap at the final state, automatic restart with and without the override, the every-second-session interrupt count, the slot placement of paired results, and trigger precedence in dual mode.

// File: rtl/adc_autoseq_pkg.sv
package adc_autoseq_pkg;

  // Width of a table state index; the table holds 2**SEQ_STATE_W states.
  localparam int SEQ_STATE_W = 4;
  localparam int SEQ_STATES  = 1 << SEQ_STATE_W;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_WAIT  = 2'd2
  } phase_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic                   wrEn;     // store the returned result(s)
    logic                   wrPair;   // also store the B result at slot+1
    logic [SEQ_STATE_W-1:0] wrSlot;   // destination register
    logic [SEQ_STATE_W-1:0] selState; // table entry to present
  } dpStrobe_t;

endpackage

// File: rtl/adc_autoseq_ctrl.sv
module adc_autoseq_ctrl
  import adc_autoseq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cascadeMode,
  input  logic                   simulMode,
  input  logic                   contRun,
  input  logic                   wrapOverride,
  input  logic [SEQ_STATE_W-1:0] maxConvA,
  input  logic [SEQ_STATE_W-2:0] maxConvB,
  input  logic                   trigA,
  input  logic                   trigB,
  input  logic                   rstSeqA,
  input  logic                   rstSeqB,
  input  logic                   intEnA,
  input  logic                   intModeA,
  input  logic                   intEnB,
  input  logic                   intModeB,
  input  logic                   convDone,
  output logic                   convStart,
  output logic                   convPair,
  output logic                   busyA,
  output logic                   busyB,
  output logic                   irqA,
  output logic                   irqB,
  output dpStrobe_t              strobe
);

  localparam int SW = SEQ_STATE_W;
  localparam logic [SW-1:0] HALF_BASE = SW'(1 << (SW - 1));
  localparam logic [SW-1:0] ALL_ONES  = {SW{1'b1}};

  phase_t        phase;
  logic          owner;
  logic [SW-1:0] cnt;
  logic [SW-1:0] ptr    [2];
  logic [1:0]    parity;
  logic [1:0]    irqReg;

  logic [SW-1:0] baseOf [2];
  logic [SW-1:0] lastOf [2];
  logic [SW-1:0] limOf  [2];
  logic [1:0]    rstHit;
  logic [1:0]    intEn;
  logic [1:0]    intMode;

  logic [SW-1:0] curPtr;
  logic [SW-1:0] offset;
  logic [SW-1:0] offTwice;
  logic [SW-1:0] pairMask;
  logic [SW-1:0] pairSlot;
  logic [SW-1:0] nextPtr;
  logic          isLast;
  logic          cntHit;
  logic          sessEnd;
  logic          doneOk;

  // Range limits and counts for each sequencer in the current mode.
  always_comb begin
    baseOf[0] = '0;
    baseOf[1] = HALF_BASE;
    lastOf[0] = cascadeMode ? ALL_ONES : HALF_BASE - 1'b1;
    lastOf[1] = ALL_ONES;
    limOf[0]  = cascadeMode ? maxConvA : {1'b0, maxConvA[SW-2:0]};
    limOf[1]  = {1'b0, maxConvB};
    rstHit    = {rstSeqB & ~cascadeMode, rstSeqA};
    intEn     = {intEnB, intEnA};
    intMode   = {intModeB, intModeA};
  end

  // Pointer step and result slot of the owning sequencer.
  always_comb begin
    curPtr   = ptr[owner];
    offset   = curPtr - baseOf[owner];
    offTwice = {offset[SW-2:0], 1'b0};
    pairMask = cascadeMode ? ALL_ONES : HALF_BASE - 1'b1;
    pairSlot = (offTwice & pairMask) | baseOf[owner];
    isLast   = (curPtr == lastOf[owner]);
    cntHit   = (cnt == limOf[owner]);
    sessEnd  = isLast | cntHit;
    if (isLast)
      nextPtr = baseOf[owner];
    else if (contRun && !wrapOverride && cntHit)
      nextPtr = baseOf[owner];
    else
      nextPtr = curPtr + 1'b1;
    doneOk   = (phase == PH_WAIT) && convDone && !rstHit[owner];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      owner  <= 1'b0;
      cnt    <= '0;
      ptr[0] <= '0;
      ptr[1] <= HALF_BASE;
      parity <= '0;
      irqReg <= '0;
    end else begin
      irqReg <= '0;
      unique case (phase)
        PH_IDLE: begin
          if (trigA && !rstHit[0]) begin
            owner <= 1'b0;
            cnt   <= '0;
            phase <= PH_ISSUE;
          end else if (trigB && !cascadeMode && !rstHit[1]) begin
            owner <= 1'b1;
            cnt   <= '0;
            phase <= PH_ISSUE;
          end
        end
        PH_ISSUE: phase <= PH_WAIT;
        PH_WAIT: begin
          if (doneOk) begin
            ptr[owner] <= nextPtr;
            if (sessEnd) begin
              parity[owner] <= ~parity[owner];
              irqReg[owner] <= intEn[owner] & (~intMode[owner] | parity[owner]);
              cnt           <= '0;
              phase         <= contRun ? PH_ISSUE : PH_IDLE;
            end else begin
              cnt   <= cnt + 1'b1;
              phase <= PH_ISSUE;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
      // Reset commands override whatever the sequencer was doing.
      for (int s = 0; s < 2; s++) begin
        if (rstHit[s]) begin
          ptr[s]    <= baseOf[s];
          parity[s] <= 1'b0;
          if (phase != PH_IDLE && owner == s[0])
            phase <= PH_IDLE;
        end
      end
    end
  end

  assign convStart = (phase == PH_ISSUE);
  assign convPair  = convStart & simulMode;
  assign busyA     = (phase != PH_IDLE) & ~owner;
  assign busyB     = (phase != PH_IDLE) & owner;
  assign irqA      = irqReg[0];
  assign irqB      = irqReg[1];

  always_comb begin
    strobe.wrEn     = doneOk;
    strobe.wrPair   = simulMode;
    strobe.wrSlot   = simulMode ? pairSlot : curPtr;
    strobe.selState = curPtr;
  end

endmodule

// File: rtl/adc_autoseq_dp.sv
module adc_autoseq_dp
  import adc_autoseq_pkg::*;
#(
  parameter int CH_W   = 4,
  parameter int DATA_W = 12,
  parameter int RES_W  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobe_t                    strobe,
  input  logic [SEQ_STATES*CH_W-1:0]   chanTable,
  input  logic [DATA_W-1:0]            convData,
  input  logic [DATA_W-1:0]            convDataB,
  output logic [CH_W-1:0]              convChan,
  output logic [SEQ_STATES*RES_W-1:0]  resultsFlat
);

  localparam int PAD_W = RES_W - DATA_W;

  logic [CH_W-1:0]        selEntry;
  logic [SEQ_STATE_W-1:0] slotNext;
  logic [RES_W-1:0]       wordA;
  logic [RES_W-1:0]       wordB;

  always_comb begin
    selEntry = chanTable[strobe.selState*CH_W +: CH_W];
    convChan = strobe.wrPair ? {1'b0, selEntry[CH_W-2:0]} : selEntry;
    slotNext = strobe.wrSlot + 1'b1;
    wordA    = {convData,  {PAD_W{1'b0}}};
    wordB    = {convDataB, {PAD_W{1'b0}}};
  end

  for (genvar k = 0; k < SEQ_STATES; k++) begin : g_res
    logic [RES_W-1:0] resReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        resReg <= '0;
      else if (strobe.wrEn && strobe.wrSlot == SEQ_STATE_W'(k))
        resReg <= wordA;
      else if (strobe.wrEn && strobe.wrPair && slotNext == SEQ_STATE_W'(k))
        resReg <= wordB;
    end
    assign resultsFlat[k*RES_W +: RES_W] = resReg;
  end

endmodule

// File: rtl/adc_autoseq.sv
module adc_autoseq
  import adc_autoseq_pkg::*;
#(
  parameter int CH_W   = 4,
  parameter int DATA_W = 12,
  parameter int RES_W  = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cascadeMode,
  input  logic                        simulMode,
  input  logic                        contRun,
  input  logic                        wrapOverride,
  input  logic [SEQ_STATE_W-1:0]      maxConvA,
  input  logic [SEQ_STATE_W-2:0]      maxConvB,
  input  logic [SEQ_STATES*CH_W-1:0]  chanTable,
  input  logic                        trigA,
  input  logic                        trigB,
  input  logic                        rstSeqA,
  input  logic                        rstSeqB,
  input  logic                        intEnA,
  input  logic                        intModeA,
  input  logic                        intEnB,
  input  logic                        intModeB,
  output logic                        convStart,
  output logic [CH_W-1:0]             convChan,
  output logic                        convPair,
  input  logic                        convDone,
  input  logic [DATA_W-1:0]           convData,
  input  logic [DATA_W-1:0]           convDataB,
  output logic                        busyA,
  output logic                        busyB,
  output logic                        irqA,
  output logic                        irqB,
  output logic [SEQ_STATES*RES_W-1:0] resultsFlat
);

  dpStrobe_t strobe;

  adc_autoseq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .cascadeMode(cascadeMode), .simulMode(simulMode),
    .contRun(contRun), .wrapOverride(wrapOverride),
    .maxConvA(maxConvA), .maxConvB(maxConvB),
    .trigA(trigA), .trigB(trigB),
    .rstSeqA(rstSeqA), .rstSeqB(rstSeqB),
    .intEnA(intEnA), .intModeA(intModeA),
    .intEnB(intEnB), .intModeB(intModeB),
    .convDone(convDone),
    .convStart(convStart), .convPair(convPair),
    .busyA(busyA), .busyB(busyB),
    .irqA(irqA), .irqB(irqB),
    .strobe(strobe)
  );

  adc_autoseq_dp #(.CH_W(CH_W), .DATA_W(DATA_W), .RES_W(RES_W)) i_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .chanTable(chanTable),
    .convData(convData), .convDataB(convDataB),
    .convChan(convChan), .resultsFlat(resultsFlat)
  );

endmodule

// File: rtl/adc_autoseq_chk.sv
module adc_autoseq_chk
  import adc_autoseq_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int RES_W = 16
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        cascadeMode,
  input logic                        trigB,
  input logic                        rstSeqA,
  input logic                        convStart,
  input logic [CH_W-1:0]             convChan,
  input logic                        convPair,
  input logic                        convDone,
  input logic                        busyA,
  input logic                        busyB,
  input logic                        irqA,
  input logic                        irqB,
  input logic [SEQ_STATES*RES_W-1:0] resultsFlat
);

  assert_start_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  assert_start_in_session_R11: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> (busyA || busyB));

  assert_single_owner_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(busyA && busyB));

  assert_reset_idles_R7: assert property (@(posedge clk) disable iff (!rstN)
    rstSeqA |=> !busyA);

  assert_irqa_after_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqA |-> $past(convDone));

  assert_irqb_after_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqB |-> $past(convDone));

  assert_cascade_ignores_b_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cascadeMode && trigB && !busyB) |=> !busyB);

  assert_pair_channel_R10: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && convPair) |-> !convChan[CH_W-1]);

  for (genvar k = 0; k < SEQ_STATES; k++) begin : g_just
    assert_low_nibble_R9: assert property (@(posedge clk) disable iff (!rstN)
      resultsFlat[k*RES_W +: 4] == 4'h0);
  end

endmodule

bind adc_autoseq adc_autoseq_chk #(.CH_W(CH_W), .RES_W(RES_W)) i_chk (
  .clk(clk), .rstN(rstN), .cascadeMode(cascadeMode), .trigB(trigB),
  .rstSeqA(rstSeqA), .convStart(convStart), .convChan(convChan),
  .convPair(convPair), .convDone(convDone), .busyA(busyA), .busyB(busyB),
  .irqA(irqA), .irqB(irqB), .resultsFlat(resultsFlat)
);

// File: tb/test_adc_autoseq.sv
module test_adc_autoseq;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cascadeMode = 1'b1, simulMode = 1'b0, contRun = 1'b0, wrapOverride = 1'b0;
  logic [3:0]   maxConvA = 4'd0;
  logic [2:0]   maxConvB = 3'd0;
  logic [63:0]  chanTable;
  logic         trigA = 0, trigB = 0, rstSeqA = 0, rstSeqB = 0;
  logic         intEnA = 0, intModeA = 0, intEnB = 0, intModeB = 0;
  logic         convStart, convPair, busyA, busyB, irqA, irqB;
  logic [3:0]   convChan;
  logic         convDone = 0;
  logic [11:0]  convData = 0, convDataB = 0;
  logic [255:0] resultsFlat;

  adc_autoseq i_adc_autoseq (
    .clk(clk), .rstN(rstN), .cascadeMode(cascadeMode), .simulMode(simulMode),
    .contRun(contRun), .wrapOverride(wrapOverride), .maxConvA(maxConvA),
    .maxConvB(maxConvB), .chanTable(chanTable), .trigA(trigA), .trigB(trigB),
    .rstSeqA(rstSeqA), .rstSeqB(rstSeqB), .intEnA(intEnA), .intModeA(intModeA),
    .intEnB(intEnB), .intModeB(intModeB), .convStart(convStart),
    .convChan(convChan), .convPair(convPair), .convDone(convDone),
    .convData(convData), .convDataB(convDataB), .busyA(busyA), .busyB(busyB),
    .irqA(irqA), .irqB(irqB), .resultsFlat(resultsFlat)
  );

  always #4 clk = ~clk;  // 125 MHz

  int  compared = 0, mismatched = 0;
  bit  finished = 0;

  // Reference model state
  int  mPhase = 0, mOwner = 0, mCnt = 0;
  int  mPtr[2] = '{0, 8};
  bit  mPar[2] = '{0, 0};
  bit  mIrq[2] = '{0, 0};
  int  mRes[16];

  // Observation
  int  startCount = 0, irqCountA = 0, doneCnt = 0, dataN = 0;
  int  chanLog[$];

  function automatic int entryOf(int s);
    return (5 * s + 3) % 16;
  endfunction

  function automatic logic [11:0] pick(int n);
    case (n % 5)
      0: return 12'hFFF;
      1: return 12'h001;
      2: return 12'h000;
      default: return 12'((n * 613 + 91) & 'hFFF);
    endcase
  endfunction

  function automatic int baseOf(int s); return s ? 8 : 0; endfunction
  function automatic int lastOf(int s); return (s == 0 && !cascadeMode) ? 7 : 15; endfunction
  function automatic int limOf(int s);
    if (s) return int'(maxConvB);
    return cascadeMode ? int'(maxConvA) : int'(maxConvA) & 7;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    bit rh[2];
    int oldPh, oldOw, p, sl, sz;
    bit last, hit;
    if (!rstN) begin
      mPhase = 0; mOwner = 0; mCnt = 0; mPtr[0] = 0; mPtr[1] = 8;
      mPar[0] = 0; mPar[1] = 0; mIrq[0] = 0; mIrq[1] = 0;
      for (int k = 0; k < 16; k++) mRes[k] = 0;
      return;
    end
    rh[0] = rstSeqA;
    rh[1] = rstSeqB && !cascadeMode;
    oldPh = mPhase; oldOw = mOwner;
    mIrq[0] = 0; mIrq[1] = 0;
    if (oldPh == 0) begin
      if (trigA && !rh[0]) begin mOwner = 0; mCnt = 0; mPhase = 1; end
      else if (trigB && !cascadeMode && !rh[1]) begin mOwner = 1; mCnt = 0; mPhase = 1; end
    end else if (oldPh == 1) begin
      mPhase = 2;
    end else if (convDone && !rh[oldOw]) begin
      p = mPtr[oldOw];
      if (simulMode) begin
        sz = cascadeMode ? 16 : 8;
        sl = baseOf(oldOw) + ((2 * (p - baseOf(oldOw))) % sz);
        mRes[sl] = int'(convData) * 16;
        mRes[sl + 1] = int'(convDataB) * 16;
      end else begin
        mRes[p] = int'(convData) * 16;
      end
      last = (p == lastOf(oldOw));
      hit  = (mCnt == limOf(oldOw));
      if (last) mPtr[oldOw] = baseOf(oldOw);
      else if (contRun && !wrapOverride && hit) mPtr[oldOw] = baseOf(oldOw);
      else mPtr[oldOw] = p + 1;
      if (last || hit) begin
        mIrq[oldOw] = (oldOw ? intEnB : intEnA) &&
                      (!(oldOw ? intModeB : intModeA) || mPar[oldOw]);
        mPar[oldOw] = !mPar[oldOw];
        mCnt = 0;
        mPhase = contRun ? 1 : 0;
      end else begin
        mCnt++;
        mPhase = 1;
      end
    end
    for (int s = 0; s < 2; s++) begin
      if (rh[s]) begin
        mPtr[s] = baseOf(s); mPar[s] = 0;
        if (oldPh != 0 && oldOw == s) mPhase = 0;
      end
    end
  endtask

  task automatic compareAll();
    int expChan, ent;
    chk(busyA == (mPhase != 0 && mOwner == 0), "R11", "busyA", busyA, mPhase != 0 && mOwner == 0);
    chk(busyB == (mPhase != 0 && mOwner == 1), "R11", "busyB", busyB, mPhase != 0 && mOwner == 1);
    chk(irqA == mIrq[0], "R8", "irqA", irqA, mIrq[0]);
    chk(irqB == mIrq[1], "R8", "irqB", irqB, mIrq[1]);
    chk(convStart == (mPhase == 1), "R12", "convStart", convStart, mPhase == 1);
    if (mPhase == 1) begin
      ent = int'(chanTable[4 * mPtr[mOwner] +: 4]);
      expChan = simulMode ? (ent & 7) : ent;
      chk(int'(convChan) == expChan, simulMode ? "R10" : "R1", "convChan", convChan, expChan);
      chk(convPair == simulMode, "R10", "convPair", convPair, simulMode);
    end
    for (int k = 0; k < 16; k++)
      chk(int'(resultsFlat[16 * k +: 16]) == mRes[k], "R9", $sformatf("result%0d", k),
          resultsFlat[16 * k +: 16], mRes[k]);
  endtask

  // Clock loop: compare at the falling edge, model at the rising edge,
  // converter responder drives 2 ns after the rising edge.
  initial begin
    for (int k = 0; k < 16; k++) mRes[k] = 0;
    forever begin
      @(negedge clk);
      compareAll();
      if (convStart) begin
        startCount++;
        chanLog.push_back(int'(convChan));
        doneCnt = 3;
      end
      if (irqA) irqCountA++;
      @(posedge clk);
      modelStep();
      #2;
      convDone = 1'b0;
      if (doneCnt > 0) begin
        doneCnt--;
        if (doneCnt == 0) begin
          convDone = 1'b1;
          convData = pick(dataN);
          convDataB = pick(dataN + 2) ^ 12'h5A5;
          dataN++;
        end
      end
    end
  end

  task automatic drive(bit a, bit b, bit ra, bit rb);
    @(posedge clk); #2;
    trigA = a; trigB = b; rstSeqA = ra; rstSeqB = rb;
    @(posedge clk); #2;
    trigA = 0; trigB = 0; rstSeqA = 0; rstSeqB = 0;
  endtask

  task automatic waitIdle();
    do begin @(posedge clk); #2; end while (mPhase != 0 || doneCnt != 0 || convDone);
  endtask

  task automatic clearObs();
    @(posedge clk); #2;
    startCount = 0; irqCountA = 0; chanLog.delete();
  endtask

  task automatic chkLog(string tag, int k, int exp);
    int act;
    act = (chanLog.size() > k) ? chanLog[k] : -1;
    chk(act == exp, tag, $sformatf("chanLog[%0d]", k), act, exp);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) chanTable[4 * k +: 4] = 4'(entryOf(k));
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    chk(!busyA && !busyB && !convStart && resultsFlat == '0, "R9", "reset state", busyA, 0);

    // R3/R4: cascaded, stop between triggers
    clearObs(); maxConvA = 4'd2;
    drive(1, 0, 0, 0); waitIdle();
    chk(startCount == 3, "R3", "starts per trigger", startCount, 3);
    chkLog("R1", 0, entryOf(0)); chkLog("R1", 2, entryOf(2));
    clearObs(); drive(1, 0, 0, 0); waitIdle();
    chkLog("R4", 0, entryOf(3));
    chk(startCount == 3, "R3", "second session starts", startCount, 3);

    // R4: session ends at final state, then pointer wraps
    clearObs(); maxConvA = 4'd15; drive(1, 0, 0, 0); waitIdle();
    chk(startCount == 10, "R4", "states 6..15", startCount, 10);
    clearObs(); maxConvA = 4'd1; drive(1, 0, 0, 0); waitIdle();
    chkLog("R4", 0, entryOf(0));

    // R8: every-second and every interrupt, and gating
    drive(0, 0, 1, 0); clearObs();
    maxConvA = 4'd0; intEnA = 1; intModeA = 1;
    for (int i = 0; i < 4; i++) begin drive(1, 0, 0, 0); waitIdle(); end
    chk(irqCountA == 2, "R8", "every-second irq count", irqCountA, 2);
    clearObs(); intModeA = 0;
    for (int i = 0; i < 2; i++) begin drive(1, 0, 0, 0); waitIdle(); end
    chk(irqCountA == 2, "R8", "every irq count", irqCountA, 2);
    clearObs(); intEnA = 0; drive(1, 0, 0, 0); waitIdle();
    chk(irqCountA == 0, "R8", "disabled irq count", irqCountA, 0);

    // R2: dual ranges, B in its upper half; R3 low three bits for A
    @(posedge clk); #2 cascadeMode = 0;
    drive(0, 0, 1, 1); clearObs();
    maxConvB = 3'd2; drive(0, 1, 0, 0); waitIdle();
    chk(startCount == 3, "R3", "B starts", startCount, 3);
    chkLog("R2", 0, entryOf(8)); chkLog("R2", 2, entryOf(10));
    clearObs(); maxConvA = 4'd9; drive(1, 0, 0, 0); waitIdle();
    chk(startCount == 2, "R3", "dual A uses 3 bits", startCount, 2);
    chkLog("R2", 0, entryOf(0));
    @(posedge clk); #2 cascadeMode = 1;
    clearObs(); drive(0, 1, 0, 1); repeat (8) @(posedge clk);
    chk(startCount == 0, "R2", "trigB in cascaded mode", startCount, 0);

    // R5 and R7: automatic restart to initial state, aborted by reset
    drive(0, 0, 1, 0); clearObs();
    maxConvA = 4'd1; contRun = 1; wrapOverride = 0;
    drive(1, 0, 0, 0);
    while (startCount < 6) begin @(posedge clk); #2; end
    rstSeqA = 1; @(posedge clk); #2; rstSeqA = 0; contRun = 0;
    chk(!busyA, "R7", "busyA after reset command", busyA, 0);
    for (int k = 0; k < 6; k++) chkLog("R5", k, entryOf(k % 2));
    waitIdle();

    // R6: override keeps the pointer advancing across sessions
    clearObs(); maxConvA = 4'd2; contRun = 1; wrapOverride = 1;
    drive(1, 0, 0, 0);
    while (startCount < 7) begin @(posedge clk); #2; end
    contRun = 0; waitIdle();
    for (int k = 0; k < 7; k++) chkLog("R6", k, entryOf(k));
    wrapOverride = 0;

    // R10: paired sampling in cascaded mode
    drive(0, 0, 1, 0); clearObs();
    simulMode = 1; maxConvA = 4'd3; drive(1, 0, 0, 0); waitIdle();
    chk(startCount == 4, "R10", "paired starts", startCount, 4);
    for (int k = 0; k < 4; k++) chkLog("R10", k, entryOf(k) & 7);
    // paired in dual mode for B: slots wrap in 8..15
    @(posedge clk); #2 cascadeMode = 0;
    drive(0, 0, 0, 1); clearObs(); maxConvB = 3'd5; drive(0, 1, 0, 0); waitIdle();
    chk(startCount == 6, "R10", "paired B starts", startCount, 6);
    simulMode = 0;

    // R11: trigger while busy ignored; A wins a tie
    drive(0, 0, 1, 1); clearObs();
    maxConvB = 3'd3; drive(0, 1, 0, 0); drive(1, 0, 0, 0); waitIdle();
    chk(startCount == 4, "R11", "trigA during B session", startCount, 4);
    chkLog("R11", 0, entryOf(8));
    clearObs(); maxConvA = 4'd0; maxConvB = 3'd0; drive(1, 1, 0, 0); waitIdle();
    chk(startCount == 1, "R11", "tie starts", startCount, 1);
    chkLog("R11", 0, entryOf(0));

    // R7: reset in dual mode while B waits for done
    clearObs(); maxConvB = 3'd4; drive(0, 1, 0, 0);
    while (startCount < 2) begin @(posedge clk); #2; end
    rstSeqB = 1; @(posedge clk); #2; rstSeqB = 0;
    chk(!busyB, "R7", "busyB after reset command", busyB, 0);
    waitIdle();
    clearObs(); maxConvB = 3'd0; drive(0, 1, 0, 0); waitIdle();
    chkLog("R7", 0, entryOf(8));

    finished = 1;
    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule